// File: doc/BRIEF.md
# Per-Crossing Trigger Bit Prescaler

This block thins a vector of trigger decision bits. Every bit has its own prescale factor. A bit with factor F is let through on one fired occurrence out of every F. The thinning is done separately for each bunch-crossing slot of the readout window, so each (slot, bit) pair owns a private down-counter. The crossing is named by a signed offset around the centre of the window. Offset `o` selects slot `NSLOTS/2 + o`.

A counter moves only when its bit fires. When a fired bit brings its counter down to zero, the bit is passed and the counter reloads from the factor. Otherwise the bit is suppressed. A factor of 0 or 1 means pass-through, and a global bypass turns prescaling off for the whole vector. A load strobe refills every counter in every slot from the current factors. It is raised on the first event and at the start of each luminosity segment. The result is registered, with one cycle of latency, and carries a valid flag.

Top module: `trig_prescaler`

## Requirements
- R1: While `rst_n` is low, `valid_o` and `bits_o` are 0 and every counter holds 1. As a result, the first fired occurrence of a bit in a slot that has never been loaded is passed.
- R2: `valid_o` equals `valid_i` of the previous clock cycle, and `bits_o` carries the decision for the vector presented in that cycle.
- R3: A signed offset `o` in the range -NSLOTS/2 to NSLOTS-1-NSLOTS/2 (-2..+2 by default) selects slot `NSLOTS/2 + o`. Events in one slot never change the counters of another slot.
- R4: Take a bit with factor F >= 2 whose counter was loaded to F. Of its fired occurrences in one slot, the 1st through (F-1)th give 0 and the Fth gives 1, after which the counter holds F again.
- R5: A bit that is 0 at the input gives 0 at the output and leaves its counter unchanged.
- R6: A bit whose factor is 0 or 1 passes its input value unchanged and does not touch its counter.
- R7: When `bypass_i` is 1, the whole input vector passes unchanged and no counter changes.
- R8: `load_i` refills every counter of every slot from the factors, whether or not `valid_i` is high. If it coincides with a valid event, that event is judged against the refilled values.
- R9: An offset outside the slot range passes the vector unchanged and changes no counter.
- R10: Bits are independent. The factor, input and counter of one bit never affect another bit's output.
- R11: `bits_o` is 0 whenever `valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| load_i | input | 1 | Refill all counters from the factors |
| valid_i | input | 1 | A decision vector is present this cycle |
| offset_i | input | OFSW (4) | Signed crossing offset inside the event |
| bits_i | input | NBITS (8) | Incoming trigger decision bits |
| factors_i | input | NBITS*CW (128) | Prescale factor of bit b at [b*CW +: CW] |
| bypass_i | input | 1 | Disable prescaling for the whole vector |
| valid_o | output | 1 | Registered valid flag |
| bits_o | output | NBITS (8) | Registered prescaled decision bits |

## Verification
Two of the block's functions can fall in the same cycle: a segment reload and a counted event in one slot. The bench provokes this directly by raising `load_i` together with `valid_i` after counters in several slots have been run partway down. A randomised phase then repeats the collision with random offsets and vectors. The scoreboard model refills every counter before judging the event, so the result is correct only if the fired bits see fresh factors. Every other slot must also restart from its factor on its next event.

// File: rtl/tp_pkg.sv
package tp_pkg;

  // Outcome of one bit lane for one event
  typedef enum logic [1:0] {
    LANE_DROP = 2'd0,   // bit suppressed or not fired
    LANE_THRU = 2'd1,   // passed without counting (unity, bypass, no slot)
    LANE_HIT  = 2'd2    // counter expired: pass and reload
  } lane_res_t;

  localparam int DEF_NBITS  = 8;
  localparam int DEF_NSLOTS = 5;
  localparam int DEF_CW     = 16;

endpackage

// File: rtl/tp_slot_map.sv
module tp_slot_map #(
  parameter int NSLOTS = 5,
  parameter int OFSW   = 4
) (
  input  logic signed [OFSW-1:0] offset_i,
  output logic [NSLOTS-1:0]      hit_o,
  output logic                   in_range_o
);

  localparam int HALF = NSLOTS / 2;
  localparam int LO   = -HALF;
  localparam int HI   = NSLOTS - 1 - HALF;

  int off_int;
  int idx;

  always_comb begin
    off_int    = int'(offset_i);
    in_range_o = (off_int >= LO) && (off_int <= HI);
    idx        = off_int + HALF;
  end

  for (genvar s = 0; s < NSLOTS; s++) begin : g_hit
    assign hit_o[s] = in_range_o && (idx == s);
  end

endmodule

// File: rtl/tp_lane.sv
module tp_lane
  import tp_pkg::*;
#(
  parameter int NSLOTS = 5,
  parameter int CW     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              valid_i,
  input  logic [NSLOTS-1:0] hit_i,
  input  logic              bypass_i,
  input  logic              fired_i,
  input  logic [CW-1:0]     factor_i,
  output logic              pass_o
);

  logic [CW-1:0] cnt_q [NSLOTS];
  logic [CW-1:0] cnt_d [NSLOTS];
  logic [CW-1:0] cur   [NSLOTS];
  logic [NSLOTS-1:0] we;
  logic [CW-1:0] sel;
  logic          unity;
  logic          counted;
  logic          expire;
  lane_res_t     res;

  // next-state logic
  always_comb begin
    for (int s = 0; s < NSLOTS; s++) begin
      cur[s] = load_i ? factor_i : cnt_q[s];
    end
    sel = '0;
    for (int s = 0; s < NSLOTS; s++) begin
      if (hit_i[s]) sel = cur[s];
    end
    unity   = bypass_i || (factor_i <= CW'(1));
    counted = valid_i && fired_i && (|hit_i) && !unity;
    expire  = (sel <= CW'(1));

    if (!valid_i || !fired_i) res = LANE_DROP;
    else if (!counted)        res = LANE_THRU;
    else if (expire)          res = LANE_HIT;
    else                      res = LANE_DROP;
    pass_o = (res != LANE_DROP);

    for (int s = 0; s < NSLOTS; s++) begin
      cnt_d[s] = cur[s];
      we[s]    = load_i;
      if (counted && hit_i[s]) begin
        cnt_d[s] = expire ? factor_i : (sel - CW'(1));
        we[s]    = 1'b1;
      end
    end
  end

  // counter registers, one clock enable per slot
  for (genvar s = 0; s < NSLOTS; s++) begin : g_cnt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q[s] <= CW'(1);
      end else if (we[s]) begin
        cnt_q[s] <= cnt_d[s];
      end
    end
  end

endmodule

// File: rtl/trig_prescaler.sv
module trig_prescaler
  import tp_pkg::*;
#(
  parameter  int NBITS  = DEF_NBITS,
  parameter  int NSLOTS = DEF_NSLOTS,
  parameter  int CW     = DEF_CW,
  localparam int OFSW   = $clog2(NSLOTS) + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load_i,
  input  logic                   valid_i,
  input  logic signed [OFSW-1:0] offset_i,
  input  logic [NBITS-1:0]       bits_i,
  input  logic [NBITS*CW-1:0]    factors_i,
  input  logic                   bypass_i,
  output logic                   valid_o,
  output logic [NBITS-1:0]       bits_o
);

  logic [NSLOTS-1:0] hit;
  logic              in_range;
  logic [NBITS-1:0]  pass;
  logic              valid_d;
  logic [NBITS-1:0]  bits_d;
  logic              bits_en;

  tp_slot_map #(.NSLOTS(NSLOTS), .OFSW(OFSW)) u_map (
    .offset_i   (offset_i),
    .hit_o      (hit),
    .in_range_o (in_range)
  );

  for (genvar b = 0; b < NBITS; b++) begin : g_lane
    tp_lane #(.NSLOTS(NSLOTS), .CW(CW)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (load_i),
      .valid_i  (valid_i),
      .hit_i    (hit),
      .bypass_i (bypass_i),
      .fired_i  (bits_i[b]),
      .factor_i (factors_i[b*CW +: CW]),
      .pass_o   (pass[b])
    );
  end

  // output next-state: clear on idle cycles, load on events
  always_comb begin
    valid_d = valid_i;
    bits_en = valid_i || valid_o;
    bits_d  = valid_i ? pass : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_o <= '0;
    end else if (bits_en) begin
      bits_o <= bits_d;
    end
  end

endmodule

// File: rtl/tp_chk.sv
module tp_chk #(
  parameter  int NBITS  = 8,
  parameter  int NSLOTS = 5,
  parameter  int CW     = 16,
  localparam int OFSW   = $clog2(NSLOTS) + 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   valid_i,
  input logic signed [OFSW-1:0] offset_i,
  input logic [NBITS-1:0]       bits_i,
  input logic [NBITS*CW-1:0]    factors_i,
  input logic                   bypass_i,
  input logic                   valid_o,
  input logic [NBITS-1:0]       bits_o
);

  localparam int HALF = NSLOTS / 2;
  localparam int HI   = NSLOTS - 1 - HALF;

  logic outside;
  always_comb outside = (int'(offset_i) > HI) || (int'(offset_i) < -HALF);

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> valid_o);

  // R2
  idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> !valid_o);

  // R11
  quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> (bits_o == '0));

  // R5
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> ((bits_o & ~$past(bits_i)) == '0));

  // R7
  bypass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && bypass_i) |=> (bits_o == $past(bits_i)));

  // R9
  outside_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && outside) |=> (bits_o == $past(bits_i)));

  for (genvar b = 0; b < NBITS; b++) begin : g_unity
    // R6
    unity_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && (factors_i[b*CW +: CW] <= CW'(1))) |=> (bits_o[b] == $past(bits_i[b])));
  end

endmodule

bind trig_prescaler tp_chk #(.NBITS(NBITS), .NSLOTS(NSLOTS), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .valid_i   (valid_i),
  .offset_i  (offset_i),
  .bits_i    (bits_i),
  .factors_i (factors_i),
  .bypass_i  (bypass_i),
  .valid_o   (valid_o),
  .bits_o    (bits_o)
);

// File: tb/trig_prescaler_tb.sv
module trig_prescaler_tb;

  localparam int NB = 8;
  localparam int NS = 5;
  localparam int CW = 16;
  localparam int OW = $clog2(NS) + 1;
  localparam int HALF = NS / 2;

  logic                 clk;
  logic                 rst_n;
  logic                 load_i;
  logic                 valid_i;
  logic signed [OW-1:0] offset_i;
  logic [NB-1:0]        bits_i;
  logic [NB*CW-1:0]     factors_i;
  logic                 bypass_i;
  logic                 valid_o;
  logic [NB-1:0]        bits_o;

  trig_prescaler u_dut (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .valid_i(valid_i),
    .offset_i(offset_i), .bits_i(bits_i), .factors_i(factors_i),
    .bypass_i(bypass_i), .valid_o(valid_o), .bits_o(bits_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference state from the requirements
  int fac [NB];
  int mcnt [NS][NB];

  // scoreboard queues
  logic          exp_v_q [$];
  logic [NB-1:0] exp_b_q [$];
  string         tag_q   [$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input bit v, input int off, input logic [NB-1:0] b,
                      input bit byp, input bit ld, input string tag);
    logic [NB-1:0] e;
    bit inr;
    int s;
    @(negedge clk);
    valid_i  = v;
    offset_i = OW'(off);
    bits_i   = b;
    bypass_i = byp;
    load_i   = ld;
    if (ld) for (int i = 0; i < NS; i++) for (int j = 0; j < NB; j++) mcnt[i][j] = fac[j];
    e = '0;
    inr = (off >= -HALF) && (off <= NS - 1 - HALF);
    s = off + HALF;
    if (v) begin
      for (int j = 0; j < NB; j++) begin
        if (!b[j])                           e[j] = 1'b0;
        else if (byp || fac[j] <= 1 || !inr) e[j] = 1'b1;
        else if (mcnt[s][j] <= 1) begin      e[j] = 1'b1; mcnt[s][j] = fac[j]; end
        else begin                           e[j] = 1'b0; mcnt[s][j]--; end
      end
    end
    exp_v_q.push_back(v);
    exp_b_q.push_back(e);
    tag_q.push_back(v ? tag : "R11");
  endtask

  // monitor: compare each result one cycle after its inputs
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_v_q.size() > 0) begin
        logic ev;
        logic [NB-1:0] eb;
        string t;
        ev = exp_v_q.pop_front();
        eb = exp_b_q.pop_front();
        t  = tag_q.pop_front();
        chk((valid_o === ev) && (bits_o === eb), t, "valid/bits",
            {23'd0, valid_o, bits_o}, {23'd0, ev, eb});
      end
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R2 watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int f_init [NB] = '{1, 0, 2, 3, 4, 5, 7, 2};
    rst_n = 1'b0; load_i = 0; valid_i = 0; offset_i = '0; bits_i = '0; bypass_i = 0;
    for (int j = 0; j < NB; j++) begin
      fac[j] = f_init[j];
      factors_i[j*CW +: CW] = CW'(f_init[j]);
    end
    for (int i = 0; i < NS; i++) for (int j = 0; j < NB; j++) mcnt[i][j] = 1;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(valid_o === 1'b0, "R1", "valid_o in reset", {31'd0, valid_o}, 32'd0);
    chk(bits_o === '0, "R1", "bits_o in reset", {24'd0, bits_o}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: unloaded counters pass the first fired bit
    step(1, 0, 8'hFC, 0, 0, "R1");
    step(0, 0, 8'hFF, 0, 0, "R11");
    // R8: load with no event
    step(0, 0, 8'h00, 0, 1, "R8");
    // R4 / R6 / R10: repeated fired vectors in one slot
    for (int k = 0; k < 9; k++) step(1, 0, 8'hFF, 0, 0, "R4");
    for (int k = 0; k < 4; k++) step(1, 0, 8'h55, 0, 0, "R10");
    // R5: zeros leave counters untouched
    for (int k = 0; k < 3; k++) step(1, 0, 8'h00, 0, 0, "R5");
    step(1, 0, 8'hFF, 0, 0, "R5");
    // R3: slots are independent
    for (int r = 0; r < 3; r++)
      for (int o = -2; o <= 2; o++) step(1, o, (o == 1) ? 8'hF0 : 8'hFF, 0, 0, "R3");
    // R9: out-of-range offsets
    step(1, 3, 8'hFF, 0, 0, "R9");
    step(1, -3, 8'hFF, 0, 0, "R9");
    step(1, 7, 8'hAA, 0, 0, "R9");
    step(1, -8, 8'hFF, 0, 0, "R9");
    step(1, 0, 8'hFF, 0, 0, "R9");
    // R7: bypass
    for (int k = 0; k < 3; k++) step(1, -1, 8'hFF, 1, 0, "R7");
    step(1, -1, 8'hFF, 0, 0, "R7");
    // R8: load coinciding with an event
    step(1, 2, 8'hFF, 0, 0, "R8");
    step(1, 1, 8'hFF, 0, 1, "R8");
    for (int o = -2; o <= 2; o++) step(1, o, 8'hFF, 0, 0, "R8");
    // R2: gaps between events
    for (int k = 0; k < 6; k++) step(k % 2, 0, 8'hFF, 0, 0, "R2");
    // R10: random mix
    for (int k = 0; k < 400; k++) begin
      int o;
      o = int'($urandom_range(6)) - 3;
      step($urandom_range(3) != 0, o, NB'($urandom), $urandom_range(15) == 0,
           $urandom_range(31) == 0, "R10");
    end
    step(0, 0, 8'h00, 0, 0, "R11");
    repeat (3) @(posedge clk);
    #1;
    chk(exp_v_q.size() == 0, "R2", "scoreboard drained", exp_v_q.size(), 32'd0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule